// File: doc/BRIEF.md
# Two-by-two programmable logic fabric

This block is a miniature reconfigurable fabric. Four logic cells sit in a 2x2 grid and five switch boxes sit between and around them. Three external inputs and one external output connect the fabric to the rest of the chip. Each logic cell holds a 2-input truth table, a flip-flop, and a select bit that chooses either the table's direct result or its registered copy as the cell output. Each switch box holds six enables. Each enable closes one fixed connection from a source (an external input or a cell output) to a destination (a cell input or the external output).

All configuration arrives as one 50-bit serial stream. The stream has a fixed layout that includes every cell and every box, whether or not it is used. That stream alone defines what the fabric computes. After the last bit, a one-cycle done pulse releases the output. Loading a new stream changes the function.

Top module: `fab_mini2x2`

## Requirements
- R1: While `cfg_en` is high, each clock shifts `cfg_bit` into a 50-bit chain, and earlier bits move toward the most significant end. After 50 shifts, stream bit k (k=0 first) sits at chain position 49-k. While `cfg_en` is low, `cfg_bit` is ignored and the chain holds.
- R2: The chain layout from the top is: cell 0, cell 1, cell 2, cell 3 (5 bits each), then box 0 to box 4 (6 bits each). In a cell field, bits [4:1] are the truth table and bit 0 is the register select. Values in fields of unused cells do not affect the routed function.
- R3: With select 0, the cell output is combinational and equals truth[{a,b}], where `a` is the high index bit. For example, AND is 1000, OR is 1110, XOR is 0110, and "pass b" is 1010.
- R4: With select 1, the cell output is the truth-table result captured at the previous rising clock edge. The cell flip-flop resets to 0.
- R5: Source numbers are in0=0, in1=1, in2=2, cell0..cell3=3..6. Box bit j of box m is connection 6m+j. The connections are:
  - box0: in0->c0.a, in1->c0.b, in0->c1.a, in1->c1.b, in2->c0.b, in2->c1.a
  - box1: c0->c1.a, c0->c1.b, in2->c1.b, c0->c3.a, c1->c3.a, in1->c3.a
  - box2: in2->c2.a, in2->c2.b, c0->c2.b, in0->c2.a, in1->c2.b, c0->c2.a
  - box3: in2->c3.b, c1->c3.b, in0->c3.a, in1->c3.b, c2->c3.a, c2->c3.b
  - box4: c3->out, c2->out, c1->out, c0->out, in2->out, c1->c2.a
- R6: When several enabled connections share a destination, the one from the lowest-numbered source drives it.
- R7: A cell input or the external output that no enabled connection reaches reads 0.
- R8: `fab_out` is 0 from reset until a `cfg_done` pulse, and again from the cycle after `cfg_en` is seen high until the next `cfg_done`.
- R9: A new stream loaded after a previous one replaces the whole function.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_bit | input | 1 | Serial configuration data |
| cfg_done | input | 1 | One-cycle pulse that marks the load as complete |
| fab_in | input | 3 | External inputs in0..in2 |
| fab_out | output | 1 | External fabric output |

## Verification
The first stream maps a registered (in0 AND in1) OR in2 over two cells, with junk in the unused cells. All eight input combinations are applied. They tell the AND term apart from the OR term, and a sample taken before the edge tells registered from combinational. A second stream maps XOR onto another cell and another output tap, which shows that the function really changed. A priority stream drives one cell input from both in1 and in2 with opposite values, which separates the lowest-source rule from the highest. A stream with a cell whose inputs are left undriven shows that undriven nets read 0. A stream with no output tap shows that an unreached output reads 0.

// File: rtl/fab_pkg.sv
package fab_pkg;
    localparam int N_IN      = 3;
    localparam int N_CELLS   = 4;
    localparam int N_BOXES   = 5;
    localparam int LUT_IN    = 2;
    localparam int LUT_BITS  = 1 << LUT_IN;
    localparam int CELL_W    = LUT_BITS + 1;
    localparam int BOX_W     = 6;
    localparam int CELLS_W   = N_CELLS * CELL_W;
    localparam int CHAIN_W   = CELLS_W + N_BOXES * BOX_W;
    localparam int N_SRC     = N_IN + N_CELLS;
    localparam int N_DST     = N_CELLS * LUT_IN + 1;
    localparam int N_CONN    = N_BOXES * BOX_W;
    localparam int SRC_W     = $clog2(N_SRC);
    localparam int DST_W     = $clog2(N_DST);
    localparam int DST_OUT   = N_DST - 1;

    typedef struct packed {
        logic [LUT_BITS-1:0] truth;
        logic                reg_sel;
    } cell_cfg_t;

    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic [DST_W-1:0] dst;
    } conn_t;

    // source: 0..2 external inputs, 3..6 cells; dest: 2*cell+port, 8 = output
    function automatic conn_t conn_of(input int k);
        conn_t c;
        case (k)
            0:  c = '{src: 3'd0, dst: 4'd0};
            1:  c = '{src: 3'd1, dst: 4'd1};
            2:  c = '{src: 3'd0, dst: 4'd2};
            3:  c = '{src: 3'd1, dst: 4'd3};
            4:  c = '{src: 3'd2, dst: 4'd1};
            5:  c = '{src: 3'd2, dst: 4'd2};
            6:  c = '{src: 3'd3, dst: 4'd2};
            7:  c = '{src: 3'd3, dst: 4'd3};
            8:  c = '{src: 3'd2, dst: 4'd3};
            9:  c = '{src: 3'd3, dst: 4'd6};
            10: c = '{src: 3'd4, dst: 4'd6};
            11: c = '{src: 3'd1, dst: 4'd6};
            12: c = '{src: 3'd2, dst: 4'd4};
            13: c = '{src: 3'd2, dst: 4'd5};
            14: c = '{src: 3'd3, dst: 4'd5};
            15: c = '{src: 3'd0, dst: 4'd4};
            16: c = '{src: 3'd1, dst: 4'd5};
            17: c = '{src: 3'd3, dst: 4'd4};
            18: c = '{src: 3'd2, dst: 4'd7};
            19: c = '{src: 3'd4, dst: 4'd7};
            20: c = '{src: 3'd0, dst: 4'd6};
            21: c = '{src: 3'd1, dst: 4'd7};
            22: c = '{src: 3'd5, dst: 4'd6};
            23: c = '{src: 3'd5, dst: 4'd7};
            24: c = '{src: 3'd6, dst: 4'd8};
            25: c = '{src: 3'd5, dst: 4'd8};
            26: c = '{src: 3'd4, dst: 4'd8};
            27: c = '{src: 3'd3, dst: 4'd8};
            28: c = '{src: 3'd2, dst: 4'd8};
            29: c = '{src: 3'd4, dst: 4'd4};
            default: c = '{src: 3'd0, dst: 4'd0};
        endcase
        return c;
    endfunction
endpackage

// File: rtl/fab_cfg_chain.sv
module fab_cfg_chain
    import fab_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_en,
    input  logic               cfg_bit,
    input  logic               cfg_done,
    output logic [CHAIN_W-1:0] chain,
    output logic               loaded
);
    always_ff @(posedge clk) begin
        if (rst) begin
            chain  <= '0;
            loaded <= 1'b0;
        end else begin
            if (cfg_en) begin
                chain  <= {chain[CHAIN_W-2:0], cfg_bit};
                loaded <= 1'b0;
            end else if (cfg_done) begin
                loaded <= 1'b1;
            end
        end
    end

    assert_shift_in_R1: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> chain[0] == $past(cfg_bit));
    assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> $stable(chain));
endmodule

// File: rtl/fab_cell.sv
module fab_cell
    import fab_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cell_cfg_t cfg,
    input  logic      in_a,
    input  logic      in_b,
    output logic      cell_out
);
    logic comb_val;
    logic q;

    assign comb_val = cfg.truth[{in_a, in_b}];

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= comb_val;
    end

    assign cell_out = cfg.reg_sel ? q : comb_val;

    assert_reg_capture_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg) == cfg && cfg.reg_sel) |-> cell_out == $past(cfg.truth[{in_a, in_b}]));
endmodule

// File: rtl/fab_router.sv
module fab_router
    import fab_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_CONN-1:0] conn_en,
    input  logic [N_SRC-1:0]  src_val,
    output logic [N_DST-1:0]  dst_val
);
    always_comb begin
        for (int d = 0; d < N_DST; d++) begin
            dst_val[d] = 1'b0;
            for (int s = N_SRC - 1; s >= 0; s--) begin
                for (int k = 0; k < N_CONN; k++) begin
                    if (conn_en[k] && int'(conn_of(k).src) == s && int'(conn_of(k).dst) == d)
                        dst_val[d] = src_val[s];
                end
            end
        end
    end

    // source 0 is top priority: any enabled connection from it decides its destination
    generate
        for (genvar k = 0; k < N_CONN; k++) begin : g_prio
            if (conn_of(k).src == '0) begin : g_src0
                assert_top_prio_R6: assert property (@(posedge clk) disable iff (rst)
                    conn_en[k] |-> dst_val[conn_of(k).dst] == src_val[0]);
            end
        end
    endgenerate
endmodule

// File: rtl/fab_mini2x2.sv
module fab_mini2x2
    import fab_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_en,
    input  logic            cfg_bit,
    input  logic            cfg_done,
    input  logic [N_IN-1:0] fab_in,
    output logic            fab_out
);
    logic [CHAIN_W-1:0] chain;
    logic               loaded;
    logic [N_CELLS-1:0] cell_q;
    logic [N_DST-1:0]   dst_val;
    logic [N_CONN-1:0]  conn_en;

    fab_cfg_chain u_chain (
        .clk      (clk),
        .rst      (rst),
        .cfg_en   (cfg_en),
        .cfg_bit  (cfg_bit),
        .cfg_done (cfg_done),
        .chain    (chain),
        .loaded   (loaded)
    );

    // box m occupies chain[BOX_W*(N_BOXES-m)-1 -: BOX_W]
    generate
        for (genvar m = 0; m < N_BOXES; m++) begin : g_box
            assign conn_en[m*BOX_W +: BOX_W] = chain[BOX_W*(N_BOXES-m)-1 -: BOX_W];
        end
        for (genvar c = 0; c < N_CELLS; c++) begin : g_cell
            fab_cell u_cell (
                .clk      (clk),
                .rst      (rst),
                .cfg      (cell_cfg_t'(chain[CHAIN_W-1-c*CELL_W -: CELL_W])),
                .in_a     (dst_val[2*c]),
                .in_b     (dst_val[2*c+1]),
                .cell_out (cell_q[c])
            );
        end
    endgenerate

    fab_router u_route (
        .clk     (clk),
        .rst     (rst),
        .conn_en (conn_en),
        .src_val ({cell_q, fab_in}),
        .dst_val (dst_val)
    );

    assign fab_out = loaded & dst_val[DST_OUT];

    assert_gate_R8: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> fab_out == 1'b0);
endmodule

// File: tb/fab_mini2x2_tb_top.sv
module fab_mini2x2_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_en = 1'b0;
    logic       cfg_bit = 1'b0;
    logic       cfg_done = 1'b0;
    logic [2:0] fab_in = 3'b000;
    logic       fab_out;
    int         n_checks = 0;
    int         n_errors = 0;
    bit         finished = 1'b0;

    always #2 clk = ~clk;

    fab_mini2x2 dut_i (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
        .cfg_done(cfg_done), .fab_in(fab_in), .fab_out(fab_out)
    );

    function automatic logic [49:0] mk(input logic [4:0] c0, input logic [4:0] c1,
                                       input logic [4:0] c2, input logic [4:0] c3,
                                       input logic [5:0] s0, input logic [5:0] s1,
                                       input logic [5:0] s2, input logic [5:0] s3,
                                       input logic [5:0] s4);
        return {c0, c1, c2, c3, s0, s1, s2, s3, s4};
    endfunction

    task automatic check(input string req, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic shift_stream(input logic [49:0] s);
        for (int i = 49; i >= 0; i--) begin
            @(negedge clk);
            cfg_en = 1'b1;
            cfg_bit = s[i];
        end
        @(negedge clk);
        cfg_en = 1'b0;
        cfg_bit = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        cfg_done = 1'b1;
        @(negedge clk);
        cfg_done = 1'b0;
    endtask

    task automatic apply_comb(input logic [2:0] v);
        @(negedge clk);
        fab_in = v;
        #1;
    endtask

    // registered (in0 AND in1) OR in2 across cells 0 and 2, junk in unused cells
    task automatic t_and_or_reg();
        logic [49:0] s;
        s = mk(5'b10000, 5'b10101, 5'b11101, 5'b11111,
               6'b000011, 6'b000000, 6'b100010, 6'b000000, 6'b000010);
        @(negedge clk);
        #1 check("R8 reset output", fab_out, 1'b0);
        shift_stream(s);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            cfg_bit = ~cfg_bit;   // ignored: R1
        end
        cfg_bit = 1'b0;
        apply_comb(3'b111);
        @(negedge clk);
        #1 check("R8 held before done", fab_out, 1'b0);
        pulse_done();
        for (int v = 0; v < 8; v++) begin
            logic [2:0] x;
            x = 3'(v);
            @(negedge clk);
            fab_in = x;
            @(negedge clk);
            #1 check("R1 R2 R3 R5 registered and-or", fab_out,
                     (x[0] & x[1]) | x[2]);
        end
        // after 3'b111, drop to 000: old value holds until the edge (R4)
        @(negedge clk);
        fab_in = 3'b000;
        #1 check("R4 holds before edge", fab_out, 1'b1);
        @(negedge clk);
        #1 check("R4 updates after edge", fab_out, 1'b0);
    endtask

    // reload: XOR on cell 1, tapped through box4 bit 2
    task automatic t_reload_xor();
        logic [49:0] s;
        s = mk(5'b00000, 5'b01100, 5'b00000, 5'b00000,
               6'b001100, 6'b000000, 6'b000000, 6'b000000, 6'b000100);
        fab_in = 3'b011;
        shift_stream(s);
        #1 check("R8 gated after reload", fab_out, 1'b0);
        pulse_done();
        for (int v = 0; v < 8; v++) begin
            logic [2:0] x;
            x = 3'(v);
            apply_comb(x);
            check("R9 R3 xor after reload", fab_out, x[0] ^ x[1]);
        end
    endtask

    // cell0.b driven by both in1 (src 1) and in2 (src 2); cell0 passes b
    task automatic t_priority();
        logic [49:0] s;
        s = mk(5'b10100, 5'b00000, 5'b00000, 5'b00000,
               6'b010010, 6'b000000, 6'b000000, 6'b000000, 6'b001000);
        shift_stream(s);
        pulse_done();
        apply_comb(3'b100);
        check("R6 lower source wins (0)", fab_out, 1'b0);
        apply_comb(3'b010);
        check("R6 lower source wins (1)", fab_out, 1'b1);
    endtask

    // cell3 inputs undriven, truth 0001 gives 1 only for a=b=0
    task automatic t_undriven();
        logic [49:0] s;
        s = mk(5'b00000, 5'b00000, 5'b00000, 5'b00010,
               6'b000000, 6'b000000, 6'b000000, 6'b000000, 6'b000001);
        shift_stream(s);
        pulse_done();
        apply_comb(3'b111);
        check("R7 undriven cell inputs", fab_out, 1'b1);
        s = mk(5'b10100, 5'b00000, 5'b00000, 5'b00000,
               6'b000010, 6'b000000, 6'b000000, 6'b000000, 6'b000000);
        shift_stream(s);
        pulse_done();
        apply_comb(3'b111);
        check("R7 undriven output", fab_out, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_and_or_reg();
        t_reload_xor();
        t_priority();
        t_undriven();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule